// File: doc/BRIEF.md
# Two-Lane Serial ADC Word Deframer

This block rebuilds 12-bit converter samples that arrive as two serial bit streams with a frame clock. The two lanes are called the high lane and the low lane. Each lane delivers six bits per sample, most significant first. The block shifts the bits in, uses the frame clock to find word boundaries, and presents each finished sample as a parallel word with a one-cycle valid strobe. Words leave in the order they arrived. The converter's fixed pipeline latency is not compensated.

Two static settings select how the stream is decoded. The first is the lane distribution. In interleaved mode the high lane holds the odd-weighted bits and the low lane holds the even-weighted bits. In split mode the high lane holds the upper half of the word and the low lane holds the lower half. The second setting is the capture rate. In single rate, each lane gives one bit per active cycle. In double rate, each lane gives two bits per active cycle, so no dual-edge flops are needed.

A rising transition of the frame clock marks the first bit of a word. If a marker arrives while a word is only partly collected, the block raises an alignment error, drops the partial word, and starts over on that marker.

Top module: `adc_lane_deframer`

## Requirements
- R1: With `cfg_bytewise_i`=0 (interleaved mode), the k-th bit of a word on the high lane (k=0..5) is sample bit 11-2k. The k-th bit on the low lane is sample bit 10-2k.
- R2: With `cfg_bytewise_i`=1 (split mode), the k-th bit of a word on the high lane is sample bit 11-k. The k-th bit on the low lane is sample bit 5-k.
- R3: With `cfg_ddr_i`=0 (single rate), an active cycle (`bit_vld_i`=1) carries one bit slot taken from index 0 of `lane_hi_i`, `lane_lo_i` and `frame_lvl_i`. Index 1 is ignored.
- R4: With `cfg_ddr_i`=1 (double rate), an active cycle carries two bit slots. Index 0 is the earlier slot (rising edge) and index 1 is the later slot (falling edge).
- R5: A word starts at a slot whose frame level is 1 when the frame level of the previous bit slot was 0. The previous slot may lie in an earlier active cycle.
- R6: After reset, bits are discarded until the first frame marker. The frame level counts as 1 at reset, so a frame clock that is already high at release does not start a word.
- R7: `sample_vld_o` pulses for exactly one cycle, in the cycle after the cycle that delivered a word's sixth bit pair. `sample_o` holds that word while the pulse is high.
- R8: A marker that arrives when one to five bit pairs of a word have been collected does three things. It raises `align_err_o` for one cycle, one cycle later. It drops the partial word without emitting it. It starts a new word with that slot.
- R9: Both configuration inputs are sampled during reset and while the block waits for its first marker. Changes made after that have no effect until the next reset.
- R10: During reset, `sample_o`, `sample_vld_o` and `align_err_o` are all 0.
- R11: Cycles with `bit_vld_i`=0 add no bits and do not change the frame level used for marker detection.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_bytewise_i | input | 1 | Lane distribution: 0 interleaved, 1 split |
| cfg_ddr_i | input | 1 | Capture rate: 0 single, 1 double |
| bit_vld_i | input | 1 | Bit slots are present this cycle |
| lane_hi_i | input | 2 | High-lane bits; [0] earlier slot, [1] later slot |
| lane_lo_i | input | 2 | Low-lane bits; [0] earlier slot, [1] later slot |
| frame_lvl_i | input | 2 | Frame clock level for each slot |
| sample_o | output | 12 | Reassembled sample |
| sample_vld_o | output | 1 | One-cycle strobe for a new sample |
| align_err_o | output | 1 | One-cycle strobe when a marker cuts a word short |

## Verification
The hardest situation to reach is a marker that lands mid-word. In double rate it can fall in either slot of a cycle, and the partial word must vanish without disturbing the next one. The stimulus forces this case by inserting a four-pair fragment between complete random words. Idle cycles are scattered at random, so the fragment boundary lands on both slot positions.

A second hard case is a configuration change after the block has locked. The bench flips both configuration inputs in the middle of a stream and keeps serializing in the original format. Any word decoded in the new format then shows up as a mismatch.

// File: rtl/adc_deframe_pkg.sv
package adc_deframe_pkg;
  localparam int unsigned DDR_SLOTS = 2;

  typedef enum logic {
    FMT_INTERLEAVED = 1'b0,
    FMT_SPLIT       = 1'b1
  } lane_fmt_e;
endpackage

// File: rtl/adc_frame_edge.sv
module adc_frame_edge #(
  parameter int unsigned SLOTS = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SLOTS-1:0] slot_vld,
  input  logic [SLOTS-1:0] lvl,
  output logic [SLOTS-1:0] mark
);
  logic last_q;
  logic last_n;

  // Walk the slots oldest first; only valid slots move the remembered level.
  always_comb begin
    logic prev;
    prev = last_q;
    mark = '0;
    for (int s = 0; s < SLOTS; s++) begin
      if (slot_vld[s]) begin
        mark[s] = lvl[s] & ~prev;
        prev    = lvl[s];
      end
    end
    last_n = prev;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) last_q <= 1'b1;
    else        last_q <= last_n;
  end
endmodule

// File: rtl/adc_lane_collect.sv
module adc_lane_collect #(
  parameter int unsigned LANE_BITS = 6,
  parameter int unsigned SLOTS     = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [SLOTS-1:0]     slot_vld,
  input  logic [SLOTS-1:0]     mark,
  input  logic [SLOTS-1:0]     bit_hi,
  input  logic [SLOTS-1:0]     bit_lo,
  output logic                 word_done,
  output logic [LANE_BITS-1:0] hi_word,
  output logic [LANE_BITS-1:0] lo_word,
  output logic                 align_err,
  output logic                 hunting
);
  localparam int unsigned CNT_W = $clog2(LANE_BITS + 1);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(LANE_BITS);

  logic [CNT_W-1:0]     cnt_q, cnt_n;
  logic [LANE_BITS-1:0] hi_q, hi_n, lo_q, lo_n;
  logic                 lock_q, lock_n;

  always_comb begin
    cnt_n     = cnt_q;
    hi_n      = hi_q;
    lo_n      = lo_q;
    lock_n    = lock_q;
    word_done = 1'b0;
    align_err = 1'b0;
    hi_word   = hi_q;
    lo_word   = lo_q;
    for (int s = 0; s < SLOTS; s++) begin
      if (slot_vld[s]) begin
        if (mark[s]) begin
          align_err = align_err | (lock_n & (cnt_n != '0));
          hi_n   = {{(LANE_BITS-1){1'b0}}, bit_hi[s]};
          lo_n   = {{(LANE_BITS-1){1'b0}}, bit_lo[s]};
          cnt_n  = CNT_W'(1);
          lock_n = 1'b1;
        end else if (lock_n) begin
          hi_n  = {hi_n[LANE_BITS-2:0], bit_hi[s]};
          lo_n  = {lo_n[LANE_BITS-2:0], bit_lo[s]};
          cnt_n = cnt_n + CNT_W'(1);
        end
        if (cnt_n == FULL) begin
          word_done = 1'b1;
          hi_word   = hi_n;
          lo_word   = lo_n;
          cnt_n     = '0;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      hi_q   <= '0;
      lo_q   <= '0;
      lock_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_n;
      hi_q   <= hi_n;
      lo_q   <= lo_n;
      lock_q <= lock_n;
    end
  end

  assign hunting = ~lock_q;
endmodule

// File: rtl/adc_word_merge.sv
module adc_word_merge
  import adc_deframe_pkg::*;
#(
  parameter int unsigned LANE_BITS = 6
) (
  input  lane_fmt_e              fmt,
  input  logic [LANE_BITS-1:0]   hi_word,
  input  logic [LANE_BITS-1:0]   lo_word,
  output logic [2*LANE_BITS-1:0] word
);
  function automatic logic [2*LANE_BITS-1:0] merge(
    input lane_fmt_e f, input logic [LANE_BITS-1:0] h, input logic [LANE_BITS-1:0] l);
    logic [2*LANE_BITS-1:0] w;
    if (f == FMT_SPLIT) begin
      w = {h, l};
    end else begin
      for (int i = 0; i < int'(LANE_BITS); i++) begin
        w[2*i+1] = h[i];
        w[2*i]   = l[i];
      end
    end
    return w;
  endfunction

  assign word = merge(fmt, hi_word, lo_word);
endmodule

// File: rtl/adc_lane_deframer.sv
module adc_lane_deframer
  import adc_deframe_pkg::*;
#(
  parameter int unsigned SAMPLE_W = 12
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cfg_bytewise_i,
  input  logic                 cfg_ddr_i,
  input  logic                 bit_vld_i,
  input  logic [DDR_SLOTS-1:0] lane_hi_i,
  input  logic [DDR_SLOTS-1:0] lane_lo_i,
  input  logic [DDR_SLOTS-1:0] frame_lvl_i,
  output logic [SAMPLE_W-1:0]  sample_o,
  output logic                 sample_vld_o,
  output logic                 align_err_o
);
  localparam int unsigned LANE_BITS = SAMPLE_W / 2;

  lane_fmt_e            cfg_fmt_q, fmt_eff;
  logic                 cfg_ddr_q, ddr_eff;
  logic [DDR_SLOTS-1:0] slot_vld, mark_w;
  logic                 marker_any_w, hunting_w, done_w, err_w;
  logic [LANE_BITS-1:0] hi_w, lo_w;
  logic [SAMPLE_W-1:0]  merged_w;

  // Configuration is live only while hunting for the first marker.
  assign fmt_eff = hunting_w ? lane_fmt_e'(cfg_bytewise_i) : cfg_fmt_q;
  assign ddr_eff = hunting_w ? cfg_ddr_i : cfg_ddr_q;

  always_comb begin
    slot_vld    = '0;
    slot_vld[0] = bit_vld_i;
    for (int s = 1; s < int'(DDR_SLOTS); s++) slot_vld[s] = bit_vld_i & ddr_eff;
  end

  assign marker_any_w = |mark_w;

  adc_frame_edge #(.SLOTS(DDR_SLOTS)) edge_i (
    .clk(clk), .rst_n(rst_n), .slot_vld(slot_vld), .lvl(frame_lvl_i), .mark(mark_w)
  );

  adc_lane_collect #(.LANE_BITS(LANE_BITS), .SLOTS(DDR_SLOTS)) coll_i (
    .clk(clk), .rst_n(rst_n), .slot_vld(slot_vld), .mark(mark_w),
    .bit_hi(lane_hi_i), .bit_lo(lane_lo_i), .word_done(done_w),
    .hi_word(hi_w), .lo_word(lo_w), .align_err(err_w), .hunting(hunting_w)
  );

  adc_word_merge #(.LANE_BITS(LANE_BITS)) merge_i (
    .fmt(fmt_eff), .hi_word(hi_w), .lo_word(lo_w), .word(merged_w)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_fmt_q    <= FMT_INTERLEAVED;
      cfg_ddr_q    <= 1'b0;
      sample_o     <= '0;
      sample_vld_o <= 1'b0;
      align_err_o  <= 1'b0;
    end else begin
      if (hunting_w) begin
        cfg_fmt_q <= lane_fmt_e'(cfg_bytewise_i);
        cfg_ddr_q <= cfg_ddr_i;
      end
      if (done_w) sample_o <= merged_w;
      sample_vld_o <= done_w;
      align_err_o  <= err_w;
    end
  end
endmodule

// File: rtl/adc_lane_deframer_chk.sv
module adc_lane_deframer_chk (
  input logic clk,
  input logic rst_n,
  input logic sample_vld_o,
  input logic align_err_o,
  input logic hunting_w,
  input logic marker_any_w,
  input logic cfg_fmt_q,
  input logic cfg_ddr_q
);
  a_r7_vld_single: assert property (@(posedge clk) disable iff (!rst_n)
    sample_vld_o |=> !sample_vld_o);

  a_r6_no_emit_hunting: assert property (@(posedge clk) disable iff (!rst_n)
    hunting_w |=> !sample_vld_o);

  a_r8_err_needs_marker: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(align_err_o) |-> $past(marker_any_w));

  a_r8_err_drops_word: assert property (@(posedge clk) disable iff (!rst_n)
    align_err_o |-> !sample_vld_o);

  a_r9_cfg_held: assert property (@(posedge clk) disable iff (!rst_n)
    !hunting_w |=> ($stable(cfg_fmt_q) && $stable(cfg_ddr_q)));
endmodule

bind adc_lane_deframer adc_lane_deframer_chk chk_i (
  .clk(clk), .rst_n(rst_n), .sample_vld_o(sample_vld_o), .align_err_o(align_err_o),
  .hunting_w(hunting_w), .marker_any_w(marker_any_w),
  .cfg_fmt_q(cfg_fmt_q), .cfg_ddr_q(cfg_ddr_q)
);

// File: tb/adc_lane_deframer_tb.sv
module adc_lane_deframer_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_bytewise_i = 1'b0, cfg_ddr_i = 1'b0, bit_vld_i = 1'b0;
  logic [1:0]  lane_hi_i = '0, lane_lo_i = '0, frame_lvl_i = '0;
  logic [11:0] sample_o;
  logic        sample_vld_o, align_err_o;

  int checks = 0, errors = 0, err_seen = 0;
  bit qa[$], qb[$], qf[$];
  logic [11:0] exp_q[$];
  logic prev_vld = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  adc_lane_deframer dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_bytewise_i(cfg_bytewise_i), .cfg_ddr_i(cfg_ddr_i),
    .bit_vld_i(bit_vld_i), .lane_hi_i(lane_hi_i), .lane_lo_i(lane_lo_i),
    .frame_lvl_i(frame_lvl_i), .sample_o(sample_o), .sample_vld_o(sample_vld_o),
    .align_err_o(align_err_o)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Serialize a word the way the converter does (R1, R2, R5): first slot of each word has frame high.
  task automatic push_word(input logic [11:0] w, input bit split, input int nbits);
    for (int i = 0; i < nbits; i++) begin
      qa.push_back(split ? w[11-i] : w[11-2*i]);
      qb.push_back(split ? w[5-i]  : w[10-2*i]);
      qf.push_back(i < 3);
    end
  endtask

  // Output monitor away from the active edge.
  always @(negedge clk) begin
    if (rst_n) begin
      if (sample_vld_o) begin
        check(!prev_vld, "R7 vld single-cycle", 32'(prev_vld), 0);
        if (exp_q.size() == 0) check(1'b0, "R6/R8 unexpected word", 32'(sample_o), 0);
        else begin
          logic [11:0] e;
          e = exp_q.pop_front();
          check(sample_o == e, "R1/R2/R3/R4 word value", 32'(sample_o), 32'(e));
        end
      end
      if (align_err_o) err_seen++;
      prev_vld = sample_vld_o;
    end else prev_vld = 1'b0;
  end

  task automatic drive_all(input bit ddr, input int flip_at);
    int sent = 0;
    bit flipped = 0;
    while (qa.size() > 0) begin
      @(posedge clk); #1;
      if ($urandom % 4 == 0) begin
        bit_vld_i   = 1'b0;          // R11: idle cycle carries garbage
        lane_hi_i   = 2'($urandom);
        lane_lo_i   = 2'($urandom);
        frame_lvl_i = 2'($urandom);
      end else begin
        bit_vld_i = 1'b1;
        lane_hi_i[0] = qa.pop_front(); lane_lo_i[0] = qb.pop_front(); frame_lvl_i[0] = qf.pop_front();
        sent++;
        if (ddr && qa.size() > 0) begin
          lane_hi_i[1] = qa.pop_front(); lane_lo_i[1] = qb.pop_front(); frame_lvl_i[1] = qf.pop_front();
          sent++;
        end else begin
          lane_hi_i[1] = 1'($urandom); lane_lo_i[1] = 1'($urandom); frame_lvl_i[1] = 1'($urandom); // R3
        end
        if (!flipped && flip_at >= 0 && sent >= flip_at) begin
          flipped = 1;
          cfg_bytewise_i = ~cfg_bytewise_i;   // R9
          cfg_ddr_i      = ~cfg_ddr_i;
        end
      end
    end
    @(posedge clk); #1;
    bit_vld_i = 1'b0;
  endtask

  task automatic run_case(input bit split, input bit ddr, input int nwords,
                          input bit partial, input bit flip, input bit directed);
    @(posedge clk); #1;
    rst_n = 1'b0;
    cfg_bytewise_i = split; cfg_ddr_i = ddr; bit_vld_i = 1'b0;
    repeat (2) @(posedge clk);
    #1;
    check(sample_o == 0 && !sample_vld_o && !align_err_o, "R10 reset outputs",
          {18'd0, sample_o, sample_vld_o, align_err_o}, 0);
    qa.delete(); qb.delete(); qf.delete(); exp_q.delete();
    err_seen = 0;
    rst_n = 1'b1;
    // R6: leading fragment with frame already high at release, never a word start
    for (int i = 0; i < 4; i++) begin
      qa.push_back(1'($urandom)); qb.push_back(1'($urandom)); qf.push_back(i < 2);
    end
    for (int k = 0; k < nwords; k++) begin
      logic [11:0] w;
      w = 12'($urandom);
      if (directed && k == 0) w = 12'hFFF;
      if (directed && k == 1) w = 12'h000;
      if (directed && k == 2) w = 12'hA5C;
      if (partial && k == 2) push_word(12'($urandom), split, 4);   // R8 fragment
      push_word(w, split, 6);
      exp_q.push_back(w);
    end
    drive_all(ddr, flip ? 20 : -1);
    repeat (4) @(posedge clk);
    #1;
    check(exp_q.size() == 0, "R5/R11 all words emitted", exp_q.size(), 0);
    check(err_seen == int'(partial), "R8 align error count", err_seen, int'(partial));
  endtask

  initial begin
    void'($urandom(32'd4711));
    run_case(0, 0, 8, 0, 0, 1);   // R1 R3
    run_case(1, 0, 8, 0, 0, 1);   // R2 R3
    run_case(0, 1, 8, 0, 0, 1);   // R1 R4
    run_case(1, 1, 8, 0, 0, 0);   // R2 R4
    run_case(0, 1, 10, 1, 0, 0);  // R8 double rate
    run_case(1, 0, 10, 1, 0, 0);  // R8 single rate
    run_case(1, 1, 10, 0, 1, 0);  // R9
    run_case(0, 0, 10, 0, 1, 0);  // R9
    for (int r = 0; r < 4; r++) run_case(r[0], r[1], 12, r[0] ^ r[1], 0, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule